// File: doc/BRIEF.md
# Precision Time-of-Day Counter

This block keeps the time of day as three unsigned fields: 32-bit seconds, 30-bit nanoseconds and a 32-bit fraction of a nanosecond in units of 2^-32 ns. It advances the time once per reference clock cycle. At the nominal 125 MHz reference the step is 8 ns per cycle. A signed trim in 2^-32 ns units can raise or lower that step. A second trim, the temporary rate, overrides the base trim for a programmed number of cycles and then gives way to it again.

Software drives the block through a command port that accepts one request per cycle. A request can load an absolute time, shift the time by a signed number of nanoseconds, set the base trim, or set a temporary trim together with its duration. A separate snapshot request captures the current time into a holding register. The block shows the live time on its outputs. It also raises a one-cycle pulse whenever counting carries nanoseconds into seconds.

Top module: `tod_counter`

## Requirements
- R1: During reset, and on the first clock edge after it, seconds, nanoseconds, fraction, `sec_pulse` and `snap_valid` are all 0. The base trim, the temporary trim and the remaining duration are all cleared.
- R2: In a cycle with no load or shift, the time advances by 8 ns plus the active trim, taken as a signed 32-bit value in 2^-32 ns units. A fraction overflow carries into nanoseconds.
- R3: A load command (`cmd_op` = 0) replaces the whole time on the next edge. Seconds come from `cmd_arg_a`, nanoseconds from `cmd_arg_b[29:0]` (which must be below 10^9) and the fraction from `cmd_arg_c`.
- R4: When counting takes nanoseconds to 10^9 or above, 10^9 is subtracted and seconds increase by 1. The nanoseconds output is therefore always below 10^9.
- R5: Seconds wrap from 2^32-1 to 0, with no extra seconds bits.
- R6: A shift command (`cmd_op` = 1) adds the signed 32-bit value `cmd_arg_a` to nanoseconds, where |value| < 10^9. A sum of 10^9 or more subtracts 10^9 and increases seconds by 1. The fraction is left unchanged.
- R7: A shift that takes nanoseconds below 0 adds 10^9 and decreases seconds by 1. Seconds wrap from 0 to 2^32-1, because negative time is not represented.
- R8: A load or shift replaces that cycle's advance entirely. No advance is added in that cycle, and `sec_pulse` stays low on the following cycle.
- R9: A base-trim command (`cmd_op` = 2) stores the signed value `cmd_arg_a`. The trim is first used on the edge after the command.
- R10: A temporary-trim command (`cmd_op` = 3) makes `cmd_arg_a` the active trim for the next `cmd_arg_b` edges, after which the base trim applies again. A duration of 0 has no effect. A new base trim written during the window takes effect only after the window ends.
- R11: A snapshot request (`snap_req`) captures the time present before the edge. That time appears on the `snap_*` outputs, with `snap_valid` high for exactly one cycle. The snapshot outputs hold their value until the next request.
- R12: `sec_pulse` is high for one cycle, in the same cycle as the new seconds value produced by a counting carry. A load or a shift never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 load, 1 shift, 2 base trim, 3 temporary trim |
| cmd_arg_a | input | 32 | Seconds, shift amount or trim value |
| cmd_arg_b | input | 32 | Nanoseconds (bits 29:0) or temporary duration |
| cmd_arg_c | input | 32 | Fraction for a load |
| snap_req | input | 1 | Capture the current time |
| tod_sec | output | 32 | Live seconds |
| tod_ns | output | 30 | Live nanoseconds |
| tod_frac | output | 32 | Live fraction, 2^-32 ns units |
| sec_pulse | output | 1 | Seconds advanced by counting |
| snap_valid | output | 1 | Snapshot captured last edge |
| snap_sec | output | 32 | Captured seconds |
| snap_ns | output | 30 | Captured nanoseconds |
| snap_frac | output | 32 | Captured fraction |

## Verification
A wrong fraction carry or a wrong trim selection appears at the outputs on the very next edge. It shows up as a nanosecond or fraction value that differs from the model by the size of the trim. A stale temporary-trim counter shows up only at the end of its window, as an extra or missing trimmed cycle, so each duration sweep runs a few cycles past its end. Faults in the carry and borrow logic are exposed by loads placed just below the 10^9 boundary and by shifts at the edges of the allowed range, including around second 0. The seconds value and `sec_pulse` then disagree with the model on the edge where the boundary is crossed.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W  = 32;
  localparam int NS_W   = 30;
  localparam int FRAC_W = 32;
  localparam int ARG_W  = 32;
  localparam int NSF_W  = NS_W + FRAC_W;
  localparam int INC_W  = FRAC_W + 8;
  localparam logic [NS_W-1:0] NS_PER_SEC = 30'd1_000_000_000;

  typedef enum logic [1:0] {
    OP_LOAD      = 2'd0,
    OP_STEP      = 2'd1,
    OP_BASE_RATE = 2'd2,
    OP_TEMP_RATE = 2'd3
  } tod_op_e;

  typedef struct packed {
    logic [SEC_W-1:0]  sec;
    logic [NS_W-1:0]   ns;
    logic [FRAC_W-1:0] frac;
  } tod_time_t;

  typedef struct packed {
    logic [NSF_W-1:0] nsf;
    logic             carry;
  } adv_res_t;

  typedef struct packed {
    logic [NS_W-1:0] ns;
    logic            borrow;
    logic            carry;
  } step_res_t;

  // Per-cycle increment in 2^-32 ns units: nominal ns plus signed trim.
  function automatic logic [INC_W-1:0] tod_increment(input logic [7:0] nom_ns,
                                                     input logic [ARG_W-1:0] trim);
    logic [INC_W-1:0] base, ext;
    base = {nom_ns, {FRAC_W{1'b0}}};
    ext  = {{(INC_W-ARG_W){trim[ARG_W-1]}}, trim};
    return base + ext;
  endfunction

  // Add an increment to the joined ns.frac value, folding one second.
  function automatic adv_res_t tod_advance(input logic [NSF_W-1:0] nsf,
                                           input logic [INC_W-1:0] inc);
    logic [NSF_W:0] sum, lim;
    adv_res_t r;
    lim = {1'b0, NS_PER_SEC, {FRAC_W{1'b0}}};
    sum = {1'b0, nsf} + {{(NSF_W+1-INC_W){1'b0}}, inc};
    if (sum >= lim) begin
      r.nsf   = NSF_W'(sum - lim);
      r.carry = 1'b1;
    end else begin
      r.nsf   = sum[NSF_W-1:0];
      r.carry = 1'b0;
    end
    return r;
  endfunction

  // Signed nanosecond shift with at most one borrow or carry.
  function automatic step_res_t tod_shift(input logic [NS_W-1:0] ns,
                                          input logic [ARG_W-1:0] amt);
    logic signed [ARG_W:0] s, lim;
    step_res_t r;
    lim = $signed({{(ARG_W+1-NS_W){1'b0}}, NS_PER_SEC});
    s   = $signed({{(ARG_W+1-NS_W){1'b0}}, ns}) + $signed({amt[ARG_W-1], amt});
    r.borrow = 1'b0;
    r.carry  = 1'b0;
    if (s < 0) begin
      r.ns = NS_W'(s + lim);
      r.borrow = 1'b1;
    end else if (s >= lim) begin
      r.ns = NS_W'(s - lim);
      r.carry = 1'b1;
    end else begin
      r.ns = NS_W'(s);
    end
    return r;
  endfunction
endpackage

// File: rtl/tod_rate_ctrl.sv
module tod_rate_ctrl
  import tod_pkg::*;
#(
  parameter int NOM_INC_NS = 8,
  parameter int DUR_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_base,
  input  logic             set_temp,
  input  logic [ARG_W-1:0] trim_arg,
  input  logic [DUR_W-1:0] dur_arg,
  output logic [INC_W-1:0] inc,
  output logic             temp_active,
  output logic             temp_expire
);
  logic [ARG_W-1:0] base_trim, temp_trim;
  logic [DUR_W-1:0] temp_left;

  assign temp_active = (temp_left != '0);
  assign temp_expire = (temp_left == DUR_W'(1)) && !set_temp;
  assign inc = tod_increment(8'(NOM_INC_NS), temp_active ? temp_trim : base_trim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_trim <= '0;
      temp_trim <= '0;
      temp_left <= '0;
    end else begin
      if (set_base) base_trim <= trim_arg;
      if (set_temp) begin
        temp_trim <= trim_arg;
        temp_left <= dur_arg;
      end else if (temp_active) begin
        temp_left <= temp_left - DUR_W'(1);
      end
    end
  end
endmodule

// File: rtl/tod_time_reg.sv
module tod_time_reg
  import tod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_load,
  input  logic             do_shift,
  input  tod_time_t        load_val,
  input  logic [ARG_W-1:0] shift_amt,
  input  logic [INC_W-1:0] inc,
  output tod_time_t        tod,
  output logic             sec_pulse,
  output logic             count_carry,
  output logic             shift_carry,
  output logic             shift_borrow
);
  adv_res_t  adv;
  step_res_t sh;
  tod_time_t nxt;

  always_comb begin
    adv = tod_advance({tod.ns, tod.frac}, inc);
    sh  = tod_shift(tod.ns, shift_amt);
    count_carry  = !do_load && !do_shift && adv.carry;
    shift_carry  = do_shift && !do_load && sh.carry;
    shift_borrow = do_shift && !do_load && sh.borrow;
    if (do_load) begin
      nxt = load_val;
    end else if (do_shift) begin
      nxt.ns   = sh.ns;
      nxt.frac = tod.frac;
      nxt.sec  = tod.sec + SEC_W'(sh.carry) - SEC_W'(sh.borrow);
    end else begin
      nxt.ns   = adv.nsf[NSF_W-1:FRAC_W];
      nxt.frac = adv.nsf[FRAC_W-1:0];
      nxt.sec  = tod.sec + SEC_W'(adv.carry);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tod       <= '0;
      sec_pulse <= 1'b0;
    end else begin
      tod       <= nxt;
      sec_pulse <= count_carry;
    end
  end
endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot
  import tod_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      snap_req,
  input  tod_time_t tod,
  output tod_time_t snap,
  output logic      snap_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap       <= '0;
      snap_valid <= 1'b0;
    end else begin
      snap_valid <= snap_req;
      if (snap_req) snap <= tod;
    end
  end
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int NOM_INC_NS = 8,
  parameter int DUR_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ARG_W-1:0]  cmd_arg_a,
  input  logic [ARG_W-1:0]  cmd_arg_b,
  input  logic [ARG_W-1:0]  cmd_arg_c,
  input  logic              snap_req,
  output logic [SEC_W-1:0]  tod_sec,
  output logic [NS_W-1:0]   tod_ns,
  output logic [FRAC_W-1:0] tod_frac,
  output logic              sec_pulse,
  output logic              snap_valid,
  output logic [SEC_W-1:0]  snap_sec,
  output logic [NS_W-1:0]   snap_ns,
  output logic [FRAC_W-1:0] snap_frac
);
  logic do_load, do_shift, set_base, set_temp;
  logic [INC_W-1:0] inc;
  logic temp_active, temp_expire;
  logic count_carry, shift_carry, shift_borrow;
  tod_time_t load_val, tod, snap;

  assign do_load  = cmd_valid && (cmd_op == OP_LOAD);
  assign do_shift = cmd_valid && (cmd_op == OP_STEP);
  assign set_base = cmd_valid && (cmd_op == OP_BASE_RATE);
  assign set_temp = cmd_valid && (cmd_op == OP_TEMP_RATE) && (cmd_arg_b[DUR_W-1:0] != '0);

  assign load_val.sec  = cmd_arg_a;
  assign load_val.ns   = cmd_arg_b[NS_W-1:0];
  assign load_val.frac = cmd_arg_c;

  tod_rate_ctrl #(.NOM_INC_NS(NOM_INC_NS), .DUR_W(DUR_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .set_base(set_base), .set_temp(set_temp),
    .trim_arg(cmd_arg_a), .dur_arg(cmd_arg_b[DUR_W-1:0]), .inc(inc),
    .temp_active(temp_active), .temp_expire(temp_expire)
  );

  tod_time_reg u_time (
    .clk(clk), .rst_n(rst_n), .do_load(do_load), .do_shift(do_shift),
    .load_val(load_val), .shift_amt(cmd_arg_a), .inc(inc), .tod(tod),
    .sec_pulse(sec_pulse), .count_carry(count_carry),
    .shift_carry(shift_carry), .shift_borrow(shift_borrow)
  );

  tod_snapshot u_snap (
    .clk(clk), .rst_n(rst_n), .snap_req(snap_req), .tod(tod),
    .snap(snap), .snap_valid(snap_valid)
  );

  assign tod_sec   = tod.sec;
  assign tod_ns    = tod.ns;
  assign tod_frac  = tod.frac;
  assign snap_sec  = snap.sec;
  assign snap_ns   = snap.ns;
  assign snap_frac = snap.frac;
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
  import tod_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [ARG_W-1:0]  cmd_arg_a,
  input logic [ARG_W-1:0]  cmd_arg_b,
  input logic [ARG_W-1:0]  cmd_arg_c,
  input logic              snap_req,
  input logic [SEC_W-1:0]  tod_sec,
  input logic [NS_W-1:0]   tod_ns,
  input logic [FRAC_W-1:0] tod_frac,
  input logic              sec_pulse,
  input logic              snap_valid,
  input logic [SEC_W-1:0]  snap_sec,
  input logic [NS_W-1:0]   snap_ns,
  input logic              temp_active,
  input logic              temp_expire,
  input logic              shift_borrow
);
  a_r4_ns_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    tod_ns < NS_PER_SEC);

  a_r3_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_LOAD) |=>
      (tod_sec == $past(cmd_arg_a) && tod_ns == $past(cmd_arg_b[NS_W-1:0]) &&
       tod_frac == $past(cmd_arg_c)));

  a_r8_cmd_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == OP_LOAD || cmd_op == OP_STEP)) |=> !sec_pulse);

  a_r12_pulse_one_sec: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (tod_sec == $past(tod_sec) + 32'd1));

  a_r7_borrow_dec_sec: assert property (@(posedge clk) disable iff (!rst_n)
    shift_borrow |=> (tod_sec == $past(tod_sec) - 32'd1 && !sec_pulse));

  a_r10_temp_expires: assert property (@(posedge clk) disable iff (!rst_n)
    temp_expire |=> !temp_active);

  a_r11_snap_capture: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> (snap_valid && snap_sec == $past(tod_sec) && snap_ns == $past(tod_ns)));
endmodule

bind tod_counter tod_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_arg_a(cmd_arg_a), .cmd_arg_b(cmd_arg_b), .cmd_arg_c(cmd_arg_c),
  .snap_req(snap_req), .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_frac(tod_frac),
  .sec_pulse(sec_pulse), .snap_valid(snap_valid), .snap_sec(snap_sec),
  .snap_ns(snap_ns), .temp_active(temp_active), .temp_expire(temp_expire),
  .shift_borrow(shift_borrow)
);

// File: tb/tod_counter_tb.sv
module tod_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [31:0] cmd_arg_a = '0, cmd_arg_b = '0, cmd_arg_c = '0;
  logic snap_req = 1'b0;
  logic [31:0] tod_sec, snap_sec, tod_frac, snap_frac;
  logic [29:0] tod_ns, snap_ns;
  logic sec_pulse, snap_valid;

  always #4 clk = ~clk;

  tod_counter u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_arg_a(cmd_arg_a), .cmd_arg_b(cmd_arg_b), .cmd_arg_c(cmd_arg_c),
    .snap_req(snap_req), .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_frac(tod_frac),
    .sec_pulse(sec_pulse), .snap_valid(snap_valid), .snap_sec(snap_sec),
    .snap_ns(snap_ns), .snap_frac(snap_frac)
  );

  localparam longint ONE_SEC = 64'd1000000000;
  localparam longint LIM = 64'd1000000000 << 32;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // Reference state: seconds plus nanoseconds in 2^-32 ns units.
  logic [31:0] m_sec;
  longint m_nsf;
  logic [31:0] m_base, m_temp, m_left;
  logic m_pulse;
  logic [31:0] m_snap_sec;
  longint m_snap_nsf;
  logic m_snap_valid;

  task automatic check(input string tag);
    logic [29:0] ens;
    logic [31:0] efr, esns;
    n_vec++;
    ens  = 30'(m_nsf >> 32);
    efr  = 32'(m_nsf);
    esns = 32'(m_snap_nsf >> 32);
    if (tod_sec !== m_sec || tod_ns !== ens || tod_frac !== efr || sec_pulse !== m_pulse ||
        snap_valid !== m_snap_valid ||
        (m_snap_valid && (snap_sec !== m_snap_sec || snap_ns !== esns[29:0] ||
                          snap_frac !== 32'(m_snap_nsf)))) begin
      n_bad++;
      $display("FAIL %s: act sec=%0d ns=%0d frac=%0d pulse=%0b sv=%0b ssec=%0d sns=%0d exp sec=%0d ns=%0d frac=%0d pulse=%0b sv=%0b ssec=%0d sns=%0d",
               tag, tod_sec, tod_ns, tod_frac, sec_pulse, snap_valid, snap_sec, snap_ns,
               m_sec, ens, efr, m_pulse, m_snap_valid, m_snap_sec, esns);
    end
  endtask

  // Drive one cycle, update the reference for the edge, compare after it.
  task automatic cyc(input bit v, input logic [1:0] op, input logic [31:0] a,
                     input logic [31:0] b, input logic [31:0] c, input bit snap,
                     input string tag);
    longint tr, t, q, s;
    cmd_valid = v; cmd_op = op; cmd_arg_a = a; cmd_arg_b = b; cmd_arg_c = c;
    snap_req = snap;
    m_snap_valid = snap;
    if (snap) begin m_snap_sec = m_sec; m_snap_nsf = m_nsf; end
    m_pulse = 1'b0;
    if (v && op == 2'd0) begin
      m_sec = a;
      m_nsf = (longint'(b[29:0]) << 32) + longint'(c);
    end else if (v && op == 2'd1) begin
      s = longint'(m_nsf >> 32) + longint'($signed(a));
      q = (s + ONE_SEC) / ONE_SEC - 1;
      m_nsf = ((s - q * ONE_SEC) << 32) + (m_nsf & 64'hFFFF_FFFF);
      m_sec = m_sec + 32'(q);
    end else begin
      tr = longint'($signed((m_left != 0) ? m_temp : m_base));
      t = m_nsf + (longint'(8) << 32) + tr;
      q = t / LIM;
      m_nsf = t % LIM;
      m_sec = m_sec + 32'(q);
      m_pulse = (q != 0);
    end
    if (v && op == 2'd2) m_base = a;
    if (v && op == 2'd3 && b != 0) begin m_temp = a; m_left = b; end
    else if (m_left != 0) m_left = m_left - 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; snap_req = 1'b0;
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] steps [8];
    logic [29:0] bases [4];
    logic [31:0] trims [7];
    steps = '{32'd1, -32'sd1, 32'd999999999, -32'sd999999999, 32'd500000000,
              -32'sd500000000, 32'd7, -32'sd8};
    bases = '{30'd0, 30'd5, 30'd999999999, 30'd500000000};
    trims = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'd12345, -32'sd12345};
    m_sec = 0; m_nsf = 0; m_base = 0; m_temp = 0; m_left = 0; m_pulse = 0;
    m_snap_sec = 0; m_snap_nsf = 0; m_snap_valid = 0;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    cyc(0, 2'd0, 0, 0, 0, 0, "R1 first edge");
    // R2 nominal counting
    idle(20, "R2 nominal");
    // R3 loads
    for (int i = 0; i < 8; i++) begin
      cyc(1, 2'd0, 32'h1000_0000 * i + i, 32'(i * 123456789), 32'(i * 32'h2345_6789), 0, "R3 load");
      idle(3, "R3 after load");
    end
    // R4 / R12 ns rollover with pulse
    cyc(1, 2'd0, 32'd77, 32'd999999990, 32'd0, 0, "R3 load");
    idle(4, "R4 R12 rollover");
    cyc(1, 2'd0, 32'd9, 32'd999999991, 32'hFFFF_FFFF, 0, "R3 load");
    cyc(1, 2'd2, 32'd1, 0, 0, 0, "R9 base");
    idle(3, "R4 frac carry");
    cyc(1, 2'd2, 32'd0, 0, 0, 0, "R9 base");
    // R5 seconds wrap
    cyc(1, 2'd0, 32'hFFFF_FFFF, 32'd999999996, 32'd0, 0, "R3 load");
    idle(3, "R5 wrap");
    // R6 / R7 shifts over bases
    foreach (bases[bi]) foreach (steps[si]) begin
      cyc(1, 2'd0, (bi == 0) ? 32'd0 : 32'd40, 32'(bases[bi]), 32'h8000_0000, 0, "R3 load");
      cyc(1, 2'd1, steps[si], 0, 0, 0, "R6 R7 shift");
      idle(2, "R6 R7 after shift");
    end
    // R8 commands at the carry cycle
    cyc(1, 2'd0, 32'd5, 32'd999999992, 0, 0, "R3 load");
    cyc(1, 2'd1, 32'd3, 0, 0, 0, "R8 shift at carry");
    cyc(1, 2'd0, 32'd6, 32'd999999999, 0, 0, "R3 load");
    cyc(1, 2'd0, 32'd6, 32'd10, 0, 0, "R8 load at carry");
    idle(2, "R8 after");
    // R9 base trims
    foreach (trims[ti]) begin
      cyc(1, 2'd2, trims[ti], 0, 0, 0, "R9 base set");
      idle(10, "R9 trimmed");
    end
    cyc(1, 2'd2, 32'd0, 0, 0, 0, "R9 base clear");
    // R10 temporary trims
    for (int d = 0; d < 6; d++) begin
      cyc(1, 2'd3, 32'h4000_0000, 32'(d), 0, 0, "R10 temp set");
      idle(8, "R10 window");
    end
    cyc(1, 2'd3, -32'sd77777, 32'd5, 0, 0, "R10 temp set");
    cyc(1, 2'd2, 32'd999, 0, 0, 0, "R10 base during temp");
    idle(2, "R10 window");
    cyc(1, 2'd3, 32'd55555, 32'd3, 0, 0, "R10 temp restart");
    idle(8, "R10 revert");
    // R11 snapshots
    cyc(0, 2'd0, 0, 0, 0, 1, "R11 snap idle");
    idle(2, "R11 hold");
    cyc(1, 2'd0, 32'd3, 32'd4, 32'd5, 1, "R11 snap with load");
    cyc(1, 2'd1, -32'sd9, 0, 0, 1, "R11 snap with shift");
    idle(2, "R11 hold");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule